// File: doc/BRIEF.md
# Parallel NOR Flash Image Streamer

This block pulls a configuration image out of a byte-wide parallel NOR flash and turns it into a serial bit stream. It owns the flash address bus, an active-low chip enable and an active-low output enable. It presents one address for a whole byte period and samples the data byte at the end of that period. It then shifts that byte out most significant bit first, one bit per bit tick, while the next byte is being fetched. A byte period is eight bit ticks, so the flash is read at one eighth of the bit rate and the output runs at full serial speed.

The bit tick is derived from the system clock by a divider. Reading always begins at the slowest divider setting. One byte of the image, at a byte offset given at start, carries a rate code. When that byte is captured, a legal code selects a shorter divider from the next byte period on, so the access window is never shortened in the middle of a byte. A strap picks whether the image begins at address zero, with the address counting up, or at the all-ones address, with the address counting down. When the last bit has left, the block raises `done` and disables the flash so that other logic can use the bus.

Top module: `nor_byte_streamer`

## Requirements
- R1: While in reset and while idle, `flash_ce_n` and `flash_oe_n` are high, and `ser_valid` and `done` are low.
- R2: In reset and while idle, `flash_addr` is all zeros when `top_strap` is low and all ones (24 bits) when `top_strap` is high.
- R3: With `top_strap` low at start, byte k of the stream (k = 0 .. N-1) is the flash content at address k.
- R4: Each byte leaves on `ser_bit` with bit 7 first and bit 0 last. `ser_valid` is high for exactly one clock per bit.
- R5: Before any rate change, consecutive bits of a byte are `DIV_SLOW` (default 8) clocks apart. A run of N bytes gives exactly 8·N `ser_valid` strobes.
- R6: With `top_strap` high at start, byte k of the stream is the flash content at address 0xFFFFFF − k.
- R7: The byte at offset `rate_offset` is a rate code. Code 3 sets 4 clocks per bit, code 6 sets 2 clocks per bit and code 12 sets 1 clock per bit. The new spacing applies to that byte and to every later byte, and never to an earlier byte.
- R8: `done` rises after the last bit of the image. While `done` is high, `flash_ce_n` and `flash_oe_n` are high.
- R9: A rate byte holding any value other than 3, 6 or 12 leaves the bit spacing at `DIV_SLOW`.
- R10: A start with `byte_count` of zero reaches `done` without any `ser_valid` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bit ticks are derived from it |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a read while idle or done |
| top_strap | input | 1 | Start-address select: 0 = bottom counting up, 1 = top counting down |
| byte_count | input | 16 | Number of image bytes to stream, captured at start |
| rate_offset | input | 16 | Byte index of the rate code, captured at start |
| flash_data | input | 8 | Data bus from the flash |
| flash_addr | output | 24 | Address bus to the flash |
| flash_ce_n | output | 1 | Active-low flash chip enable |
| flash_oe_n | output | 1 | Active-low flash output enable |
| ser_bit | output | 1 | Serial image bit |
| ser_valid | output | 1 | Strobe marking one valid `ser_bit` |
| done | output | 1 | High after the last bit until the next start |

## Verification
The assertions assume that `start` arrives only while the block is idle or done. They also assume that the flash returns the addressed byte within the slowest byte period. The bench meets both: it pulses `start` only after it has seen `done` or reset, and its flash model produces valid data a few clocks after each address change, well inside the shortest window of eight clocks. The model returns a marker byte when the address has not been stable long enough, so a shortened access window shows up as a data mismatch. The bench only writes legal or deliberately illegal codes into the rate byte, and it keeps `top_strap` steady while a read runs.

// File: rtl/nbs_pkg.sv
`timescale 1ns/1ps
package nbs_pkg;

    localparam int DIV_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } nbs_state_e;

    // Map a rate code to clocks per bit tick; an unknown code keeps the current setting.
    function automatic logic [DIV_W-1:0] rate_to_div(input logic [7:0] code,
                                                      input logic [DIV_W-1:0] cur);
        case (code)
            8'd3:    return DIV_W'(4);
            8'd6:    return DIV_W'(2);
            8'd12:   return DIV_W'(1);
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/nbs_rate_div.sv
`timescale 1ns/1ps
module nbs_rate_div
    import nbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == div_i - 1'b1);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/nbs_addr_ctr.sv
`timescale 1ns/1ps
module nbs_addr_ctr #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              top_strap_i,
    input  logic              step_i,
    input  logic              dir_down_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [ADDR_W-1:0] base;

    always_comb begin
        base = top_strap_i ? '1 : '0;
        addr_d = addr_q;
        if (load_i)      addr_d = base;
        else if (step_i) addr_d = dir_down_i ? addr_q - 1'b1 : addr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) addr_q <= top_strap_i ? '1 : '0;
        else     addr_q <= addr_d;
    end

    assign addr_o = addr_q;

    // R3 / R6: while running, the address moves by exactly one, and only after a capture
    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        $past(step_i) && !$past(load_i) |->
            addr_q == ($past(dir_down_i) ? $past(addr_q) - 1'b1 : $past(addr_q) + 1'b1));
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(step_i) && !$past(load_i) |-> $stable(addr_q));
endmodule

// File: rtl/nbs_serializer.sv
`timescale 1ns/1ps
module nbs_serializer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              emit_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              bit_o,
    output logic              vld_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic              bit_v;
        logic              vld;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.vld = emit_i;
        if (emit_i) begin
            s_d.bit_v = s_q.sh[BYTE_W-1];
            s_d.sh    = s_q.sh << 1;
        end
        if (load_i) s_d.sh = byte_i;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign bit_o = s_q.bit_v;
    assign vld_o = s_q.vld;
endmodule

// File: rtl/nor_byte_streamer.sv
`timescale 1ns/1ps
module nor_byte_streamer
    import nbs_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int CNT_W    = 16,
    parameter int DIV_SLOW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              top_strap,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [CNT_W-1:0]  rate_offset,
    input  logic [7:0]        flash_data,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              flash_ce_n,
    output logic              flash_oe_n,
    output logic              ser_bit,
    output logic              ser_valid,
    output logic              done
);
    localparam int BITS = 8;
    localparam int BP_W = $clog2(BITS);

    typedef struct packed {
        nbs_state_e       state;
        logic             dir;
        logic [BP_W-1:0]  bitpos;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] roff;
        logic             have;
        logic [DIV_W-1:0] div;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic tick, run, ld_byte, step, emit;

    nbs_rate_div u_div (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .div_i  (ctl_q.div),
        .tick_o (tick)
    );

    nbs_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk         (clk),
        .rst         (rst),
        .load_i      (ctl_q.state != ST_RUN),
        .top_strap_i (top_strap),
        .step_i      (step),
        .dir_down_i  (ctl_q.dir),
        .addr_o      (flash_addr)
    );

    nbs_serializer #(.BYTE_W(BITS)) u_ser (
        .clk    (clk),
        .rst    (rst),
        .emit_i (emit),
        .load_i (ld_byte),
        .byte_i (flash_data),
        .bit_o  (ser_bit),
        .vld_o  (ser_valid)
    );

    always_comb begin
        ctl_d   = ctl_q;
        ld_byte = 1'b0;
        step    = 1'b0;
        run     = (ctl_q.state == ST_RUN);
        emit    = run && tick && ctl_q.have;
        ctl_d.done = (ctl_q.state == ST_DONE) && !start;
        case (ctl_q.state)
            ST_RUN: begin
                if (tick) begin
                    ctl_d.bitpos = ctl_q.bitpos + 1'b1;
                    if (ctl_q.bitpos == BP_W'(BITS-1)) begin
                        if (ctl_q.idx < ctl_q.cnt) begin
                            ld_byte    = 1'b1;
                            step       = 1'b1;
                            ctl_d.idx  = ctl_q.idx + 1'b1;
                            ctl_d.have = 1'b1;
                            if (ctl_q.idx == ctl_q.roff)
                                ctl_d.div = rate_to_div(flash_data, ctl_q.div);
                        end else begin
                            ctl_d.have  = 1'b0;
                            ctl_d.state = ST_DONE;
                        end
                    end
                end
            end
            default: begin
                if (start) begin
                    ctl_d.dir    = top_strap;
                    ctl_d.cnt    = byte_count;
                    ctl_d.roff   = rate_offset;
                    ctl_d.idx    = '0;
                    ctl_d.have   = 1'b0;
                    ctl_d.bitpos = '0;
                    ctl_d.div    = DIV_W'(DIV_SLOW);
                    ctl_d.state  = (byte_count == '0) ? ST_DONE : ST_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
            ctl_q.div   <= DIV_W'(DIV_SLOW);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign flash_ce_n = (ctl_q.state != ST_RUN);
    assign flash_oe_n = (ctl_q.state != ST_RUN);
    assign done       = ctl_q.done;

    // R8: the flash is released whenever done is shown
    p_done_release_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> flash_ce_n && flash_oe_n);
    // R7: within a run the divider only changes at the close of a byte period
    p_rate_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.state == ST_RUN) && ($past(ctl_q.state) == ST_RUN) && !$stable(ctl_q.div)
            |-> $past(tick) && ($past(ctl_q.bitpos) == BP_W'(BITS-1)));
    // R9: the divider never holds anything but the slow setting or a legal fast one
    p_div_legal_r9: assert property (@(posedge clk) disable iff (rst)
        ctl_q.div == DIV_W'(DIV_SLOW) || ctl_q.div == DIV_W'(4) ||
        ctl_q.div == DIV_W'(2) || ctl_q.div == DIV_W'(1));
    // R5: bits are only strobed out of a running read
    p_valid_in_run_r5: assert property (@(posedge clk) disable iff (rst)
        ser_valid |-> $past(ctl_q.state) == ST_RUN);
    // R1: idle keeps the flash disabled and the serial output quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.state == ST_IDLE) |-> flash_ce_n && !ser_valid);
endmodule

// File: tb/tb_nor_byte_streamer.sv
`timescale 1ns/1ps
module tb_nor_byte_streamer;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        top_strap;
    logic [15:0] byte_count;
    logic [15:0] rate_offset;
    logic [7:0]  flash_data;
    logic [23:0] flash_addr;
    logic        flash_ce_n, flash_oe_n, ser_bit, ser_valid, done;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    logic [23:0] g_code_addr;
    logic [7:0]  g_code;
    bit          g_use_code;

    logic        bt [0:1023];
    int          tt [0:1023];
    int          nb = 0;

    logic [23:0] prev_addr;
    int          age;

    always #2.5 clk = ~clk;

    nor_byte_streamer dut (
        .clk(clk), .rst(rst), .start(start), .top_strap(top_strap),
        .byte_count(byte_count), .rate_offset(rate_offset),
        .flash_data(flash_data), .flash_addr(flash_addr),
        .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
        .ser_bit(ser_bit), .ser_valid(ser_valid), .done(done)
    );

    function automatic logic [7:0] img(input logic [23:0] a);
        if (g_use_code && a == g_code_addr) return g_code;
        return a[7:0] ^ 8'h5A ^ a[15:8] ^ a[23:16];
    endfunction

    // Flash model: valid data only a few clocks after the address settles
    always @(posedge clk) begin
        cyc <= cyc + 1;
        prev_addr <= flash_addr;
        if (flash_addr != prev_addr) age <= 0;
        else if (age < 1000) age <= age + 1;
    end
    assign flash_data = (!flash_ce_n && !flash_oe_n && age >= 2) ? img(flash_addr) : 8'hEE;

    always @(negedge clk) begin
        if (ser_valid && nb < 1024) begin
            bt[nb] = ser_bit;
            tt[nb] = cyc;
            nb = nb + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_div(input logic [7:0] c);
        case (c)
            8'd3:    return 4;
            8'd6:    return 2;
            8'd12:   return 1;
            default: return 8;
        endcase
    endfunction

    task automatic do_reset(input bit strap);
        top_strap = strap;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_reset();
        do_reset(1'b0);
        check(flash_ce_n && flash_oe_n, "R1", "ce/oe high after reset",
              {flash_ce_n, flash_oe_n}, 3);
        check(!ser_valid && !done, "R1", "valid/done low after reset",
              {ser_valid, done}, 0);
        check(flash_addr == 24'h0, "R2", "bottom start address", flash_addr, 0);
        do_reset(1'b1);
        check(flash_addr == 24'hFFFFFF, "R2", "top start address", flash_addr, 24'hFFFFFF);
        top_strap = 1'b0;
        @(negedge clk);
        check(flash_addr == 24'h0, "R2", "idle follows strap", flash_addr, 0);
    endtask

    task automatic run_case(input bit top, input int n, input int roff,
                            input logic [7:0] code, input string data_req,
                            input string rate_req);
        int base, guard, ndiv;
        top_strap   = top;
        byte_count  = 16'(n);
        rate_offset = 16'(roff);
        g_code      = code;
        g_use_code  = (roff < n);
        g_code_addr = top ? 24'hFFFFFF - 24'(roff) : 24'(roff);
        ndiv        = g_use_code ? exp_div(code) : 8;
        @(negedge clk);
        base  = nb;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(guard < 20000, "R8", "done reached (watchdog)", guard, 20000);
        check(flash_ce_n && flash_oe_n, "R8", "flash released at done",
              {flash_ce_n, flash_oe_n}, 3);
        check(nb - base == 8 * n, (n == 0) ? "R10" : "R5", "strobe count",
              nb - base, 8 * n);
        if (nb - base == 8 * n) begin
            for (int k = 0; k < n; k++) begin
                logic [23:0] a;
                logic [7:0]  got;
                bit          gaps_ok;
                int          gap, bad_gap;
                a = top ? 24'hFFFFFF - 24'(k) : 24'(k);
                for (int i = 0; i < 8; i++) got[7-i] = bt[base + 8*k + i];
                check(got == img(a), (k == 0) ? "R4" : data_req, "byte content",
                      got, img(a));
                gap = (g_use_code && k >= roff) ? ndiv : 8;
                gaps_ok = 1'b1;
                bad_gap = 0;
                for (int i = 1; i < 8; i++) begin
                    if (tt[base + 8*k + i] - tt[base + 8*k + i - 1] != gap) begin
                        gaps_ok = 1'b0;
                        bad_gap = tt[base + 8*k + i] - tt[base + 8*k + i - 1];
                    end
                end
                check(gaps_ok, (g_use_code && k >= roff) ? rate_req : "R5",
                      "bit spacing", bad_gap, gap);
            end
        end
    endtask

    initial begin
        start = 1'b0; top_strap = 1'b0; byte_count = '0; rate_offset = '0;
        g_code = '0; g_use_code = 1'b0; g_code_addr = '0;
        prev_addr = '0; age = 0;
        test_reset();
        run_case(1'b0, 5, 100, 8'h00, "R3", "R5");   // slow, counting up
        run_case(1'b1, 4, 100, 8'h00, "R6", "R5");   // slow, counting down
        run_case(1'b0, 6, 2, 8'd12, "R3", "R7");     // switch to fastest mid-image
        run_case(1'b1, 5, 0, 8'd6, "R6", "R7");      // switch at first byte, from top
        run_case(1'b0, 4, 1, 8'd3, "R3", "R7");      // moderate rate
        run_case(1'b0, 4, 1, 8'd5, "R3", "R9");      // unknown code keeps slow rate
        run_case(1'b0, 0, 0, 8'd12, "R3", "R10");    // empty image
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule